// File: doc/BRIEF.md
# Compressed Instruction Expander (stack store, add-immediate, move and add)

This block turns one 16-bit compressed instruction into the 32-bit base instruction that does the same work. It covers four compressed forms: the stack-pointer word store, add-immediate, register move and register add. It also sorts out the special code points that share their bit patterns with these forms. Those are the no-operation, the hint encodings, jump-register, jump-and-link-register and breakpoint. Every other 16-bit pattern is reported as illegal. So is the all-zero word.

Instructions enter on a valid/ready stream and leave on a second valid/ready stream. Each output word carries a hint flag and an illegal flag. A hint still produces a legal base instruction whose only destination is x0. The flag is only informational.

The parameter `REG_OUT` selects the output stage:
- With `REG_OUT=1` there is one output register. The result appears one cycle after it is accepted. The input is ready whenever the register is empty or is being drained in the same cycle. While the output is valid and not taken, the register keeps its word and the input is stalled.
- With `REG_OUT=0` the path is purely combinational. Valid passes forward and ready passes backward unchanged.

Top module: `cx_expand`

## Requirements
- R1: The stack word store (bits[1:0]=10, bits[15:13]=110) expands to `sw rs2, off(x2)`. Here rs2 = bits[6:2]. The 6-bit word offset takes its low four bits from bits[12:9] and its top two bits from bits[8:7]. The byte offset is that word offset times 4, zero-extended to 12 bits.
- R2: Add-immediate (bits[1:0]=01, bits[15:13]=000) expands to `addi rd, rd, imm`. Here rd = bits[11:7]. The immediate is bits[12] followed by bits[6:2], sign-extended from bit 5 to 12 bits.
- R3: Add-immediate is classified as follows, and the expansion of R2 is emitted in every case:
  - rd=x0 with a zero immediate is the no-operation. It expands to 0x00000013 with the hint flag low.
  - rd=x0 with a nonzero immediate raises the hint flag.
  - rd not x0 with a zero immediate raises the hint flag.
- R4: Move (bits[1:0]=10, bits[15:12]=1000) with rs2 not x0 expands to `add rd, x0, rs2`. The hint flag is high exactly when rd is x0.
- R5: In the move pattern with rs2=x0, a nonzero rd gives `jalr x0, 0(rd)` with the hint flag low. rd=x0 is reported illegal.
- R6: Add (bits[1:0]=10, bits[15:12]=1001) with rs2 not x0 expands to `add rd, rd, rs2`. The hint flag is high exactly when rd is x0.
- R7: In the add pattern with rs2=x0:
  - rd=x0 gives breakpoint 0x00100073.
  - Any other rd gives `jalr x1, 0(rd)`.
- R8: An illegal result carries the illegal flag, a zero instruction word and a low hint flag. Illegal results include the all-zero word, any word with bits[1:0]=11, and every pattern not listed in R1 to R7.
- R9: With `REG_OUT=1`, the following hold:
  - An accepted word appears on the output on the next cycle.
  - The input is ready exactly when the output is empty or being taken.
  - A valid output that is not taken holds all its fields unchanged.
- R10: With `REG_OUT=0`, the output fields follow the input in the same cycle, out_valid equals in_valid, and in_ready equals out_ready.
- R11: While reset is asserted, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Compressed word offered |
| in_ready | output | 1 | Block can take the offered word |
| in_instr | input | 16 | Compressed instruction |
| out_valid | output | 1 | Expanded word available |
| out_ready | input | 1 | Consumer takes the expanded word |
| out_instr | output | 32 | Expanded base instruction, zero when illegal |
| out_hint | output | 1 | Code point is a hint |
| out_illegal | output | 1 | Code point is illegal or out of scope |

## Verification
The bench builds two copies side by side from the same input stream. The copy named dut uses `REG_OUT=1`. A second copy uses `REG_OUT=0`, so every code point is checked both through the registered stage and through the combinational path. The registered copy is also stalled with out_ready low while a second word waits. This brings the hold-and-block behaviour and the next-cycle hand-over into reach. The combinational copy checks that ready passes straight back.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int CW   = 16;  // compressed word width
  localparam int XW   = 32;  // base word width
  localparam int RW   = 5;   // register index width
  localparam int IMMW = 12;  // base immediate width
  localparam int OFFW = 6;   // compressed word-offset width

  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_SYSTEM = 7'b1110011;

  localparam logic [RW-1:0] X_ZERO = '0;
  localparam logic [RW-1:0] X_RA   = RW'(1);
  localparam logic [RW-1:0] X_SP   = RW'(2);

  typedef enum logic [2:0] {
    CK_ILLEGAL,
    CK_SWSP,
    CK_ADDI,
    CK_MV,
    CK_JR,
    CK_ADD,
    CK_JALR,
    CK_EBREAK
  } cx_kind_e;

  typedef struct packed {
    logic [RW-1:0]   rd;
    logic [RW-1:0]   rs2;
    logic            b12;
    logic [IMMW-1:0] imm_i;
    logic [IMMW-1:0] imm_s;
  } cx_fields_t;

  typedef struct packed {
    logic [XW-1:0] instr;
    logic          hint;
    logic          illegal;
  } cx_result_t;
endpackage

// File: rtl/cx_unpack.sv
module cx_unpack
  import cx_pkg::*;
(
  input  logic [12:2]  body,
  output cx_fields_t   fields
);
  logic [OFFW-1:0] word_off;
  logic [5:0]      imm6;

  always_comb begin
    // word offset: low nibble from body[12:9], top pair from body[8:7]
    word_off = {body[8:7], body[12:9]};
    imm6     = {body[12], body[6:2]};

    fields.rd    = body[11:7];
    fields.rs2   = body[6:2];
    fields.b12   = body[12];
    fields.imm_i = {{(IMMW-6){imm6[5]}}, imm6};
    fields.imm_s = {{(IMMW-OFFW-2){1'b0}}, word_off, 2'b00};
  end
endmodule

// File: rtl/cx_classify.sv
module cx_classify
  import cx_pkg::*;
(
  input  logic [2:0]  funct3,
  input  logic [1:0]  quad,
  input  cx_fields_t  fields,
  output cx_kind_e    kind,
  output logic        hint
);
  logic rd_zero, rs2_zero, imm_zero;

  always_comb begin
    rd_zero  = (fields.rd == X_ZERO);
    rs2_zero = (fields.rs2 == X_ZERO);
    imm_zero = (fields.imm_i == '0);
    kind     = CK_ILLEGAL;
    hint     = 1'b0;

    if (quad == 2'b01 && funct3 == 3'b000) begin
      kind = CK_ADDI;
      // nop (both zero) and normal (both nonzero) are not hints
      hint = rd_zero ^ imm_zero;
    end else if (quad == 2'b10 && funct3 == 3'b110) begin
      kind = CK_SWSP;
    end else if (quad == 2'b10 && funct3 == 3'b100) begin
      if (!fields.b12) begin
        if (!rs2_zero) begin
          kind = CK_MV;
          hint = rd_zero;
        end else if (!rd_zero) begin
          kind = CK_JR;
        end
      end else begin
        if (!rs2_zero) begin
          kind = CK_ADD;
          hint = rd_zero;
        end else if (rd_zero) begin
          kind = CK_EBREAK;
        end else begin
          kind = CK_JALR;
        end
      end
    end
  end
endmodule

// File: rtl/cx_encode.sv
module cx_encode
  import cx_pkg::*;
(
  input  cx_kind_e       kind,
  input  cx_fields_t     fields,
  output logic [XW-1:0]  word
);
  always_comb begin
    unique case (kind)
      CK_SWSP:   word = {fields.imm_s[11:5], fields.rs2, X_SP, 3'b010,
                         fields.imm_s[4:0], OP_STORE};
      CK_ADDI:   word = {fields.imm_i, fields.rd, 3'b000, fields.rd, OP_IMM};
      CK_MV:     word = {7'b0, fields.rs2, X_ZERO, 3'b000, fields.rd, OP_REG};
      CK_ADD:    word = {7'b0, fields.rs2, fields.rd, 3'b000, fields.rd, OP_REG};
      CK_JR:     word = {{IMMW{1'b0}}, fields.rd, 3'b000, X_ZERO, OP_JALR};
      CK_JALR:   word = {{IMMW{1'b0}}, fields.rd, 3'b000, X_RA, OP_JALR};
      CK_EBREAK: word = {IMMW'(1), X_ZERO, 3'b000, X_ZERO, OP_SYSTEM};
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/cx_out_stage.sv
module cx_out_stage #(
  parameter int W       = 34,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
  import cx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_instr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_instr,
  output logic          out_hint,
  output logic          out_illegal
);
  localparam int RESW = $bits(cx_result_t);

  cx_fields_t    fields;
  cx_kind_e      kind;
  logic          hint_raw;
  logic [XW-1:0] word;
  cx_result_t    res_in, res_out;

  cx_unpack u_unpack (
    .body   (in_instr[12:2]),
    .fields (fields)
  );

  cx_classify u_classify (
    .funct3 (in_instr[15:13]),
    .quad   (in_instr[1:0]),
    .fields (fields),
    .kind   (kind),
    .hint   (hint_raw)
  );

  cx_encode u_encode (
    .kind   (kind),
    .fields (fields),
    .word   (word)
  );

  always_comb begin
    res_in.instr   = word;
    res_in.hint    = hint_raw;
    res_in.illegal = (kind == CK_ILLEGAL);
  end

  cx_out_stage #(.W(RESW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign out_instr   = res_out.instr;
  assign out_hint    = res_out.hint;
  assign out_illegal = res_out.illegal;
endmodule

// File: rtl/cx_expand_chk.sv
module cx_expand_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_instr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_instr,
  input logic        out_hint,
  input logic        out_illegal
);
  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> (out_instr == 32'h0) && !out_hint); // R8

  if (REG_OUT) begin : g_reg
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_instr)
                                  && $stable(out_hint) && $stable(out_illegal)); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R9
    AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R9
    AST_BRK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_instr == 16'h9002 |=> out_instr == 32'h00100073); // R7
    AST_ZERO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_instr == 16'h0000 |=> out_illegal); // R8
  end else begin : g_comb
    AST_COMB_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready); // R10
    AST_COMB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_instr == 16'h0000 |-> out_illegal); // R8
  end
endmodule

bind cx_expand cx_expand_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_cx_expand.sv
`timescale 1ns/1ps
module tb_cx_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = 16'h0;
  logic        out_ready = 1'b1;

  logic        r_in_ready, r_out_valid, r_hint, r_ill;
  logic [31:0] r_instr;
  logic        c_in_ready, c_out_valid, c_hint, c_ill;
  logic [31:0] c_instr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cx_expand #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_instr(in_instr), .out_valid(r_out_valid), .out_ready(out_ready),
    .out_instr(r_instr), .out_hint(r_hint), .out_illegal(r_ill));

  cx_expand #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_instr(in_instr), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_instr(c_instr), .out_hint(c_hint), .out_illegal(c_ill));

  // generic base-format builders
  function automatic logic [31:0] enc_r(input logic [4:0] rs2, rs1, rd, input logic [6:0] op);
    return {7'b0, rs2, rs1, 3'b000, rd, op};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1, rd, input logic [6:0] op);
    return {imm, rs1, 3'b000, rd, op};
  endfunction
  function automatic logic [31:0] enc_sw(input logic [11:0] imm, input logic [4:0] rs2);
    return {imm[11:5], rs2, 5'd2, 3'b010, imm[4:0], 7'b0100011};
  endfunction
  // compressed builders
  function automatic logic [15:0] c_swsp(input logic [4:0] rs2, input logic [5:0] woff);
    return {3'b110, woff[3:0], woff[5:4], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] c_addi(input logic [4:0] rd, input logic [5:0] imm);
    return {3'b000, imm[5], rd, imm[4:0], 2'b01};
  endfunction
  function automatic logic [15:0] c_cr(input logic b12, input logic [4:0] rd, rs2);
    return {3'b100, b12, rd, rs2, 2'b10};
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word through both copies, consumer always ready
  task automatic xfer(input string tag, input logic [15:0] c,
                      input logic [31:0] ei, input logic eh, input logic el);
    @(negedge clk);
    in_instr = c; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk({tag, " R10 comb"}, {c_instr, c_hint, c_ill}, {ei, eh, el});
    chk("R10 comb handshake", {32'h0, c_out_valid, c_in_ready}, {32'h0, 1'b1, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " reg"}, {r_instr, r_hint, r_ill}, {ei, eh, el});
    chk("R9 next-cycle valid", {33'h0, r_out_valid}, {33'h0, 1'b1});
  endtask

  task automatic t_reset;
    in_valid = 1'b1; in_instr = 16'h0001;
    repeat (3) @(negedge clk);
    chk("R11 reset", {33'h0, r_out_valid}, 34'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {33'h0, r_out_valid}, 34'h0);
  endtask

  task automatic t_swsp;
    xfer("R1 off0", c_swsp(5'd5, 6'd0), enc_sw(12'd0, 5'd5), 1'b0, 1'b0);
    xfer("R1 off63", c_swsp(5'd31, 6'd63), enc_sw(12'd252, 5'd31), 1'b0, 1'b0);
    xfer("R1 perm", c_swsp(5'd9, 6'b010101), enc_sw(12'd84, 5'd9), 1'b0, 1'b0);
    xfer("R1 top", c_swsp(5'd1, 6'b110000), enc_sw(12'd192, 5'd1), 1'b0, 1'b0);
  endtask

  task automatic t_addi;
    xfer("R2 pos", c_addi(5'd10, 6'd5), enc_i(12'd5, 5'd10, 5'd10, 7'b0010011), 1'b0, 1'b0);
    xfer("R2 neg", c_addi(5'd12, 6'h3f), enc_i(12'hfff, 5'd12, 5'd12, 7'b0010011), 1'b0, 1'b0);
    xfer("R2 min", c_addi(5'd3, 6'h20), enc_i(12'hfe0, 5'd3, 5'd3, 7'b0010011), 1'b0, 1'b0);
  endtask

  task automatic t_addi_class;
    xfer("R3 nop", 16'h0001, 32'h00000013, 1'b0, 1'b0);
    xfer("R3 x0 imm", c_addi(5'd0, 6'd3), enc_i(12'd3, 5'd0, 5'd0, 7'b0010011), 1'b1, 1'b0);
    xfer("R3 imm0", c_addi(5'd7, 6'd0), enc_i(12'd0, 5'd7, 5'd7, 7'b0010011), 1'b1, 1'b0);
  endtask

  task automatic t_mv;
    xfer("R4 mv", c_cr(1'b0, 5'd8, 5'd9), enc_r(5'd9, 5'd0, 5'd8, 7'b0110011), 1'b0, 1'b0);
    xfer("R4 hint", c_cr(1'b0, 5'd0, 5'd4), enc_r(5'd4, 5'd0, 5'd0, 7'b0110011), 1'b1, 1'b0);
  endtask

  task automatic t_jr;
    xfer("R5 jr", c_cr(1'b0, 5'd1, 5'd0), 32'h00008067, 1'b0, 1'b0);
    xfer("R5 jr31", c_cr(1'b0, 5'd31, 5'd0), enc_i(12'd0, 5'd31, 5'd0, 7'b1100111), 1'b0, 1'b0);
    xfer("R5 reserved", c_cr(1'b0, 5'd0, 5'd0), 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_add;
    xfer("R6 add", c_cr(1'b1, 5'd3, 5'd4), enc_r(5'd4, 5'd3, 5'd3, 7'b0110011), 1'b0, 1'b0);
    xfer("R6 hint", c_cr(1'b1, 5'd0, 5'd6), enc_r(5'd6, 5'd0, 5'd0, 7'b0110011), 1'b1, 1'b0);
  endtask

  task automatic t_jalr_brk;
    xfer("R7 ebreak", 16'h9002, 32'h00100073, 1'b0, 1'b0);
    xfer("R7 jalr", c_cr(1'b1, 5'd5, 5'd0), enc_i(12'd0, 5'd5, 5'd1, 7'b1100111), 1'b0, 1'b0);
  endtask

  task automatic t_illegal;
    xfer("R8 zero", 16'h0000, 32'h0, 1'b0, 1'b1);
    xfer("R8 full", 16'hffff, 32'h0, 1'b0, 1'b1);
    xfer("R8 other q1", 16'h4085, 32'h0, 1'b0, 1'b1);
    xfer("R8 other q2", 16'h6082, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [15:0] a, b;
    logic [31:0] ea, eb;
    a = c_addi(5'd10, 6'd1); ea = enc_i(12'd1, 5'd10, 5'd10, 7'b0010011);
    b = c_cr(1'b1, 5'd3, 5'd4); eb = enc_r(5'd4, 5'd3, 5'd3, 7'b0110011);
    @(negedge clk);
    in_instr = a; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_instr = b;
    #1;
    chk("R9 stall data", {r_instr, r_hint, r_ill}, {ea, 1'b0, 1'b0});
    chk("R9 stall ready", {32'h0, r_out_valid, r_in_ready}, {32'h0, 1'b1, 1'b0});
    chk("R10 comb ready follows", {33'h0, c_in_ready}, 34'h0);
    @(negedge clk);
    chk("R9 hold", {r_instr, r_hint, r_ill}, {ea, 1'b0, 1'b0});
    out_ready = 1'b1;
    #1;
    chk("R9 drain ready", {33'h0, r_in_ready}, {33'h0, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second word", {r_instr, r_hint, r_ill}, {eb, 1'b0, 1'b0});
    @(negedge clk);
    chk("R9 empty", {33'h0, r_out_valid}, 34'h0);
  endtask

  initial begin
    t_reset();
    t_swsp();
    t_addi();
    t_addi_class();
    t_mv();
    t_jr();
    t_add();
    t_jalr_brk();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule